// File: doc/BRIEF.md
# Receiver Wake-Up Sequencer

This block is the control state machine that brings a low-power receiver out of sleep on its own. A falling edge on one of two trigger pins starts a run. The machine first powers the frequency synthesizer and waits until the synthesizer reports lock. It then waits a programmable number of ADC-clock ticks and switches the receive chain on. With the receiver on, it holds a carrier-sense window of a programmable number of filter-clock ticks. If a carrier is reported inside that window, the receiver stays on until the trigger pin goes high again. If no carrier is reported, everything is switched off and the machine goes back to sleep.

The two timing clocks are modelled as single-cycle enable strobes inside one system clock domain. An 8-bit configuration byte holds three fields:
- the trigger select in bit 7;
- the receive-wait code in bits 6:4;
- the carrier-sense code in bits 3:0.

The byte is copied into the block when a run starts. A register write made during a run therefore does not change the delays of that run. The internal copy resets to 8'h8A: trigger select 1, receive-wait code 0, carrier-sense code 10 (48 filter ticks).

Top module: `rx_wake_seq`

## Requirements
- R1: With `cfg_byte[7]`=1, a falling edge on `sel_n_pin` in the idle state starts a run. `seq_state` becomes 1 on the third rising clock edge after the pin falls, counting from the first edge that samples the low level.
- R2: With `cfg_byte[7]`=0, a falling edge on `sel_n_pin` has no effect. A falling edge on `dio_pin` starts a run only when `sep_data_en`=1, with the same latency as R1.
- R3: After lock, receive-wait codes 0 to 6 hold state 2 until the 32nd, 44th, 64th, 88th, 128th, 176th or 256th `adc_tick`. The state becomes 3 on the edge that samples that tick.
- R4: Receive-wait code 7 moves from state 1 straight to state 3 on the edge that samples `pll_locked`=1.
- R5: Carrier-sense codes 0 to 15 keep state 3 for 20, 22, 24, 26, 28, 30, 32, 36, 40, 44, 48, 52, 56, 60, 64 or 72 `filt_tick` pulses. The state becomes 5 on the edge that samples the last pulse, provided no carrier is seen.
- R6: The receive wait advances only on `adc_tick`, and the carrier-sense window advances only on `filt_tick`. The other strobe has no effect on either.
- R7: `carrier_det`=1 in state 3 moves the machine to state 4. State 4 holds until the synchronized level of the latched trigger pin is high, and then moves to state 5.
- R8: When `carrier_det` and the window's final `filt_tick` fall in the same cycle, the carrier wins and the next state is 4.
- R9: State 5 lasts exactly one cycle and is followed by state 0.
- R10: Trigger edges on either pin are ignored while a run is in progress (states 1 to 5).
- R11: The configuration byte is latched when a run starts. Changes to `cfg_byte` during a run do not alter that run's delays or its release pin.
- R12: State codes are 0 idle, 1 synthesizer start-up, 2 receive delay, 3 carrier sense, 4 receive active and 5 power-down. `synth_en` is 1 in states 1 to 4, and `rx_en` is 1 in states 3 and 4. After reset the state is 0 and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_byte | input | 8 | Configuration: [7] trigger select, [6:4] receive-wait code, [3:0] carrier-sense code |
| sep_data_en | input | 1 | Separate data pins option; enables the data-pin trigger |
| sel_n_pin | input | 1 | Select-style trigger pin, asynchronous |
| dio_pin | input | 1 | Data I/O trigger pin, asynchronous |
| pll_locked | input | 1 | Synthesizer lock indication |
| carrier_det | input | 1 | Carrier detected indication |
| adc_tick | input | 1 | One-cycle strobe of the ADC timing clock |
| filt_tick | input | 1 | One-cycle strobe of the filter timing clock |
| synth_en | output | 1 | Synthesizer power enable |
| rx_en | output | 1 | Receive chain power enable |
| seq_state | output | 3 | Current state code |

## Verification
Two events can fall in the same cycle in carrier sense: a carrier report and the filter tick that closes the window. Both mean leaving state 3, but they lead to different places. The bench runs the shortest window, holds `filt_tick` high through the first 19 ticks, and then raises `carrier_det` together with the 20th tick. It judges the outcome by `seq_state` one edge later: it must be 4 (receive active), not 5 (power-down). In the same way, a late configuration write and the lock event are made to meet within a single run, and the run's delay is checked against the latched code.

// File: rtl/rxws_pkg.sv
package rxws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PLL  = 3'd1,
    ST_DLY  = 3'd2,
    ST_CS   = 3'd3,
    ST_ACT  = 3'd4,
    ST_PD   = 3'd5
  } seq_st_t;

  localparam int CNT_W = 9;

  // Receive wait in ADC ticks: even codes 32<<k, odd codes 44<<k, code 7 none.
  function automatic logic [CNT_W-1:0] rx_wait_len(input logic [2:0] code);
    logic [CNT_W-1:0] base;
    if (code == 3'd7) return '0;
    base = code[0] ? CNT_W'(44) : CNT_W'(32);
    return base << code[2:1];
  endfunction

  // Carrier window in filter ticks: steps of 2 up to code 6, steps of 4 up to code 14, 72 last.
  function automatic logic [CNT_W-1:0] cs_wait_len(input logic [3:0] code);
    if (code == 4'd15) return CNT_W'(72);
    if (code < 4'd7)   return CNT_W'(20) + CNT_W'({code, 1'b0});
    return CNT_W'(36) + CNT_W'({code - 4'd7, 2'b00});
  endfunction

endpackage

// File: rtl/rxws_pin_edge.sv
module rxws_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= pin;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;

  assign level = sync_q[STAGES-1];
  assign fall  = prev_q & ~level;

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $past(level)) else $error("fall without prior high"); // R1
endmodule

// File: rtl/rxws_tick_counter.sv
module rxws_tick_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic [W-1:0] count,
  output logic         done
);
  logic [W-1:0] count_nx;

  assign count_nx = count + 1'b1;
  assign done     = tick && (count_nx == target);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (tick)  count <= count_nx;

  AST_CNT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(count)) else $error("count moved without tick"); // R6
endmodule

// File: rtl/rx_wake_seq.sv
module rx_wake_seq
  import rxws_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] CFG_RESET = 8'h8A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_byte,
  input  logic       sep_data_en,
  input  logic       sel_n_pin,
  input  logic       dio_pin,
  input  logic       pll_locked,
  input  logic       carrier_det,
  input  logic       adc_tick,
  input  logic       filt_tick,
  output logic       synth_en,
  output logic       rx_en,
  output logic [2:0] seq_state
);
  seq_st_t          state, state_nx;
  logic [7:0]       cfg_lat;
  logic             sel_lvl, sel_fall, dio_lvl, dio_fall;
  logic             start_evt, release_lvl, cnt_clear, cnt_tick, cnt_done;
  logic [CNT_W-1:0] rx_len, cs_len, cnt_target, cnt_val;

  rxws_pin_edge #(.STAGES(SYNC_STAGES)) u_sel_edge (
    .clk(clk), .rst_n(rst_n), .pin(sel_n_pin), .level(sel_lvl), .fall(sel_fall));
  rxws_pin_edge #(.STAGES(SYNC_STAGES)) u_dio_edge (
    .clk(clk), .rst_n(rst_n), .pin(dio_pin), .level(dio_lvl), .fall(dio_fall));

  // Trigger uses the live byte; it is latched on the same edge.
  assign start_evt   = (state == ST_IDLE) &&
                       (cfg_byte[7] ? sel_fall : (sep_data_en & dio_fall));
  assign release_lvl = cfg_lat[7] ? sel_lvl : dio_lvl;
  assign rx_len      = rx_wait_len(cfg_lat[6:4]);
  assign cs_len      = cs_wait_len(cfg_lat[3:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cfg_lat <= CFG_RESET;
    else if (start_evt) cfg_lat <= cfg_byte;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start_evt) state_nx = ST_PLL;
      ST_PLL:  if (pll_locked) state_nx = (cfg_lat[6:4] == 3'd7) ? ST_CS : ST_DLY;
      ST_DLY:  if (cnt_done) state_nx = ST_CS;
      ST_CS:   if (carrier_det) state_nx = ST_ACT;
               else if (cnt_done) state_nx = ST_PD;
      ST_ACT:  if (release_lvl) state_nx = ST_PD;
      ST_PD:   state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;

  assign cnt_clear  = (state_nx != state);
  assign cnt_tick   = ((state == ST_DLY) && adc_tick) || ((state == ST_CS) && filt_tick);
  assign cnt_target = (state == ST_DLY) ? rx_len : cs_len;

  rxws_tick_counter #(.W(CNT_W)) u_win_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .tick(cnt_tick),
    .target(cnt_target), .count(cnt_val), .done(cnt_done));

  assign synth_en  = (state == ST_PLL) || (state == ST_DLY) || (state == ST_CS) || (state == ST_ACT);
  assign rx_en     = (state == ST_CS) || (state == ST_ACT);
  assign seq_state = state;

  AST_RX_NEEDS_SYNTH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> synth_en) else $error("rx on without synth"); // R12
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synth_en) |-> $past(state) == ST_IDLE) else $error("bad start"); // R10
  AST_PD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD) |=> (state == ST_IDLE)) else $error("power-down stuck"); // R9
  AST_DLY_WAITS_ADC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DLY && !adc_tick) |=> (state == ST_DLY)) else $error("delay left without tick"); // R6
  AST_CS_WAITS_FILT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CS && !filt_tick && !carrier_det) |=> (state == ST_CS)) else $error("window left early"); // R6
  AST_CARRIER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CS && carrier_det) |=> (state == ST_ACT)) else $error("carrier lost"); // R8
  AST_DLY_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DLY) |-> (cnt_val < rx_len)) else $error("delay overrun"); // R3
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cfg_lat)) else $error("config moved in run"); // R11
endmodule

// File: tb/test_rx_wake_seq.sv
module test_rx_wake_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_byte = 8'h80;
  logic       sep_data_en = 1'b0, sel_n_pin = 1'b1, dio_pin = 1'b1;
  logic       pll_locked = 1'b0, carrier_det = 1'b0, adc_tick = 1'b0, filt_tick = 1'b0;
  logic       synth_en, rx_en;
  logic [2:0] seq_state;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_wake_seq i_rx_wake_seq (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .sep_data_en(sep_data_en),
    .sel_n_pin(sel_n_pin), .dio_pin(dio_pin), .pll_locked(pll_locked),
    .carrier_det(carrier_det), .adc_tick(adc_tick), .filt_tick(filt_tick),
    .synth_en(synth_en), .rx_en(rx_en), .seq_state(seq_state));

  int rx_tab [8]  = '{32, 44, 64, 88, 128, 176, 256, 0};
  int cs_tab [16] = '{20, 22, 24, 26, 28, 30, 32, 36, 40, 44, 48, 52, 56, 60, 64, 72};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_st(input int exp, input string tag);
    chk(seq_state, exp, tag);
    chk(synth_en, (exp >= 1 && exp <= 4), {tag, " R12 synth_en"});
    chk(rx_en, (exp == 3 || exp == 4), {tag, " R12 rx_en"});
  endtask

  // Start a run with the select pin (R1).
  task automatic start_sel(input logic [7:0] cfg);
    cfg_byte = cfg; sel_n_pin = 1'b1;
    repeat (4) step();
    sel_n_pin = 1'b0;
    step(); step();
    chk(seq_state, 0, "R1 not yet started");
    step();
    chk_st(1, "R1 started");
  endtask

  // Lock and go through the receive wait (R3/R4).
  task automatic lock_and_wait(input int code);
    pll_locked = 1'b1; step(); pll_locked = 1'b0;
    if (code == 7) chk_st(3, "R4 direct to sense");
    else begin
      chk_st(2, "R3 in delay");
      adc_tick = 1'b1;
      repeat (rx_tab[code] - 1) step();
      chk(seq_state, 2, $sformatf("R3 code %0d before last tick", code));
      step(); adc_tick = 1'b0;
      chk_st(3, $sformatf("R3 code %0d after last tick", code));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk_st(0, "R12 reset");
    rst_n = 1'b1;
    step();
    chk_st(0, "R12 after reset");

    // R3 sweep of receive-wait codes, R5 expiry with shortest window
    for (int c = 0; c < 8; c++) begin
      start_sel({1'b1, 3'(c), 4'd0});
      lock_and_wait(c);
      filt_tick = 1'b1;
      repeat (19) step();
      chk(seq_state, 3, "R5 code 0 before end");
      step(); filt_tick = 1'b0;
      chk_st(5, "R5 code 0 expired");
      step();
      chk_st(0, "R9 back to idle");
    end

    // R5 sweep of carrier-sense codes
    for (int c = 0; c < 16; c++) begin
      start_sel({4'b1111, 4'(c)});
      lock_and_wait(7);
      filt_tick = 1'b1;
      repeat (cs_tab[c] - 1) step();
      chk(seq_state, 3, $sformatf("R5 code %0d before end", c));
      step(); filt_tick = 1'b0;
      chk_st(5, $sformatf("R5 code %0d expired", c));
      step();
      chk_st(0, "R9 idle after power-down");
    end

    // R10 edges ignored during a run; R6 filter strobe ignored in delay
    start_sel(8'h80);
    dio_pin = 1'b0; sep_data_en = 1'b1; sel_n_pin = 1'b1;
    repeat (4) step();
    sel_n_pin = 1'b0; dio_pin = 1'b1;
    repeat (4) step();
    chk_st(1, "R10 edges ignored in start-up");
    sep_data_en = 1'b0;
    pll_locked = 1'b1; step(); pll_locked = 1'b0;
    filt_tick = 1'b1;
    repeat (100) step();
    filt_tick = 1'b0;
    chk_st(2, "R6 filter strobe ignored in delay");
    adc_tick = 1'b1; repeat (31) step();
    chk(seq_state, 2, "R6 delay counts adc only");
    step(); adc_tick = 1'b0;
    chk_st(3, "R6 delay done on 32nd tick");
    adc_tick = 1'b1; repeat (100) step(); adc_tick = 1'b0;
    chk_st(3, "R6 adc strobe ignored in sense");
    // R7 carrier then hold until pin high
    filt_tick = 1'b1; repeat (5) step(); filt_tick = 1'b0;
    carrier_det = 1'b1; step(); carrier_det = 1'b0;
    chk_st(4, "R7 carrier to active");
    filt_tick = 1'b1; repeat (100) step(); filt_tick = 1'b0;
    chk_st(4, "R7 active holds");
    sel_n_pin = 1'b1; step(); step();
    chk(seq_state, 4, "R7 release not yet synced");
    step();
    chk_st(5, "R7 release to power-down");
    step();
    chk_st(0, "R9 idle after release");

    // R8 carrier and final tick in same cycle
    start_sel(8'hF0);
    lock_and_wait(7);
    filt_tick = 1'b1; repeat (19) step();
    carrier_det = 1'b1; step(); carrier_det = 1'b0; filt_tick = 1'b0;
    chk_st(4, "R8 carrier beats expiry");
    sel_n_pin = 1'b1; repeat (4) step();
    chk_st(0, "R9 idle after R8 run");

    // R11 config latched at start
    start_sel(8'h90);
    cfg_byte = 8'h70;
    step();
    lock_and_wait(1);
    chk(seq_state, 3, "R11 latched wait code used");
    filt_tick = 1'b1; repeat (19) step();
    cfg_byte = 8'hFF; step(); filt_tick = 1'b0;
    chk_st(5, "R11 latched window used");
    step();

    // R2 select pin ignored when bit 7 is 0; data pin gated by option
    cfg_byte = 8'h70; sep_data_en = 1'b1; sel_n_pin = 1'b1; dio_pin = 1'b1;
    repeat (4) step();
    sel_n_pin = 1'b0; repeat (5) step();
    chk_st(0, "R2 select pin ignored");
    sep_data_en = 1'b0; dio_pin = 1'b0; repeat (5) step();
    chk_st(0, "R2 data pin needs option");
    dio_pin = 1'b1; sep_data_en = 1'b1; repeat (4) step();
    dio_pin = 1'b0; step(); step();
    chk(seq_state, 0, "R2 data pin not yet started");
    step();
    chk_st(1, "R2 data pin starts");
    cfg_byte = 8'hF0;
    lock_and_wait(7);
    carrier_det = 1'b1; step(); carrier_det = 1'b0;
    sel_n_pin = 1'b1; repeat (5) step();
    chk_st(4, "R11 release pin stays latched data pin");
    dio_pin = 1'b1; repeat (3) step();
    chk_st(5, "R7 data pin release");
    step();
    chk_st(0, "R9 final idle");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule